// File: doc/BRIEF.md
# Write-Only Pixel Command ALU

This block is the pixel-processing unit of a frame buffer. The host only ever writes to it: each write carries an opcode, a pixel address, a 32-bit pixel value and an 8-bit blend factor. The unit reads the stored pixel from a local cache, combines it with the incoming value, and writes the result back to the cache. Because the read-modify-write happens inside the block, the host bus always runs in one direction and never has to turn around.

The pipeline accepts one command per cycle and is seven stages deep. The operations are depth tests with a conditional write, a per-byte alpha blend, and bitwise merges. Commands that follow each other closely to the same pixel get the forwarded pending result. Their outcome is therefore the same as running the commands one at a time. The only thing that stalls the host is back-pressure on the cache write port.

Top module: `pix_cmd_alu`

## Requirements
- R1: After reset, cmd_ready is 1, and wr_valid and rd_en are 0.
- R2: In the cycle a command is accepted (cmd_valid and cmd_ready both high), rd_en is 1 and rd_addr equals cmd_addr. The cache returns rd_data in the next cycle and shows the contents as they were before any write at that same clock edge.
- R3: When the write port is not stalled, a writing command's result is on wr_valid/wr_addr/wr_data exactly 7 cycles after the cycle in which it was accepted.
- R4: The depth opcodes compare cmd_data with the stored value S as unsigned numbers and write cmd_data only when the test passes. Opcode 1 passes on cmd_data<S, 2 on cmd_data<=S, 3 on cmd_data>S and 4 on cmd_data==S. Opcode 0 always writes and opcode 5 never writes.
- R5: Opcode 6 blends. For each byte lane b the result is (C_b*A + S_b*(255-A) + 127)/255, using integer division. C is cmd_data, S is the stored value and A is cmd_alpha.
- R6: Opcode 8 writes C&S, 9 writes C|S, 10 writes C^S and 11 writes S&~C.
- R7: Opcodes 7 and 12 to 15 produce no cache write and leave the stored pixel unchanged.
- R8: Every write value equals the value that serial execution of all accepted commands gives. This holds for back-to-back commands to one address and under back-pressure.
- R9: While wr_valid is 1 and wr_ready is 0, cmd_ready is 0 and wr_addr/wr_data hold steady. At all other times cmd_ready is 1.
- R10: Cache writes leave in the order in which their commands were accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Host command present |
| cmd_ready | output | 1 | Command accepted this cycle when valid |
| cmd_op | input | 4 | Operation code |
| cmd_alpha | input | 8 | Blend factor |
| cmd_addr | input | AW | Pixel address |
| cmd_data | input | 32 | Incoming pixel value |
| rd_en | output | 1 | Cache read request |
| rd_addr | output | AW | Cache read address |
| rd_data | input | 32 | Cache read data, one cycle after rd_en |
| wr_valid | output | 1 | Cache write request |
| wr_ready | input | 1 | Cache accepts the write |
| wr_addr | output | AW | Cache write address |
| wr_data | output | 32 | Cache write data |

## Verification
The read request is due in the same cycle as the accept. The cache write is due exactly seven cycles later when wr_ready stays high. The bench checks the read address at the falling edge of the accept cycle. It measures the latency by counting falling edges from the accept until wr_valid rises. Under back-pressure, write timing depends on wr_ready. A scoreboard of expected writes, built from serial execution of the command stream, is therefore compared in order at each falling edge where the write handshake will complete. The stall handshake is checked on the same edges.

// File: rtl/pix_cmd_alu.sv
module pix_cmd_alu #(
  parameter int AW    = 10,
  parameter int DEPTH = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_valid,
  output logic          cmd_ready,
  input  logic [3:0]    cmd_op,
  input  logic [7:0]    cmd_alpha,
  input  logic [AW-1:0] cmd_addr,
  input  logic [31:0]   cmd_data,
  output logic          rd_en,
  output logic [AW-1:0] rd_addr,
  input  logic [31:0]   rd_data,
  output logic          wr_valid,
  input  logic          wr_ready,
  output logic [AW-1:0] wr_addr,
  output logic [31:0]   wr_data
);
  localparam int NQ = DEPTH - 1;
  localparam logic [3:0] OP_ALWAYS = 4'd0, OP_LT = 4'd1, OP_LE = 4'd2, OP_GT = 4'd3,
                         OP_EQ = 4'd4, OP_NEVER = 4'd5, OP_BLEND = 4'd6,
                         OP_AND = 4'd8, OP_OR = 4'd9, OP_XOR = 4'd10, OP_ANDN = 4'd11;

  logic          stall, fire;
  logic          p1_v;
  logic [3:0]    p1_op;
  logic [7:0]    p1_al;
  logic [AW-1:0] p1_ad;
  logic [31:0]   p1_dt;
  logic          hold_v;
  logic [31:0]   hold_d;
  logic          lw_v;
  logic [AW-1:0] lw_ad;
  logic [31:0]   lw_d;
  logic [NQ-1:0] q_v, q_we;
  logic [AW-1:0] q_ad [NQ];
  logic [31:0]   q_dt [NQ];
  logic [31:0]   base_d, old_d, res;
  logic          wen;

  assign wr_valid  = q_v[NQ-1] & q_we[NQ-1];
  assign wr_addr   = q_ad[NQ-1];
  assign wr_data   = q_dt[NQ-1];
  assign stall     = wr_valid & ~wr_ready;
  assign cmd_ready = ~stall;
  assign fire      = cmd_valid & cmd_ready;
  assign rd_en     = fire;
  assign rd_addr   = cmd_addr;

  function automatic logic [7:0] mix8(input logic [7:0] s, input logic [7:0] d, input logic [7:0] a);
    logic [15:0] acc;
    acc = 16'(s) * 16'(a) + 16'(d) * 16'(8'd255 - a) + 16'd127;
    return 8'(acc / 16'd255);
  endfunction

  always_comb begin
    base_d = hold_v ? hold_d : ((lw_v && lw_ad == p1_ad) ? lw_d : rd_data);
    old_d  = base_d;
    for (int k = NQ - 1; k >= 0; k--)
      if (q_v[k] && q_we[k] && q_ad[k] == p1_ad) old_d = q_dt[k];
  end

  always_comb begin
    res = p1_dt;
    wen = 1'b1;
    case (p1_op)
      OP_ALWAYS: wen = 1'b1;
      OP_LT:     wen = p1_dt <  old_d;
      OP_LE:     wen = p1_dt <= old_d;
      OP_GT:     wen = p1_dt >  old_d;
      OP_EQ:     wen = p1_dt == old_d;
      OP_NEVER:  wen = 1'b0;
      OP_BLEND:  for (int c = 0; c < 4; c++) res[8*c +: 8] = mix8(p1_dt[8*c +: 8], old_d[8*c +: 8], p1_al);
      OP_AND:    res = p1_dt & old_d;
      OP_OR:     res = p1_dt | old_d;
      OP_XOR:    res = p1_dt ^ old_d;
      OP_ANDN:   res = old_d & ~p1_dt;
      default:   wen = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      p1_v   <= 1'b0;
      p1_op  <= '0;
      p1_al  <= '0;
      p1_ad  <= '0;
      p1_dt  <= '0;
      hold_v <= 1'b0;
      hold_d <= '0;
      lw_v   <= 1'b0;
      lw_ad  <= '0;
      lw_d   <= '0;
      q_v    <= '0;
      q_we   <= '0;
      for (int k = 0; k < NQ; k++) begin
        q_ad[k] <= '0;
        q_dt[k] <= '0;
      end
    end else begin
      lw_v  <= wr_valid & wr_ready;
      lw_ad <= wr_addr;
      lw_d  <= wr_data;
      if (!stall) begin
        p1_v    <= fire;
        p1_op   <= cmd_op;
        p1_al   <= cmd_alpha;
        p1_ad   <= cmd_addr;
        p1_dt   <= cmd_data;
        hold_v  <= 1'b0;
        q_v[0]  <= p1_v;
        q_we[0] <= p1_v & wen;
        q_ad[0] <= p1_ad;
        q_dt[0] <= res;
        for (int k = 1; k < NQ; k++) begin
          q_v[k]  <= q_v[k-1];
          q_we[k] <= q_we[k-1];
          q_ad[k] <= q_ad[k-1];
          q_dt[k] <= q_dt[k-1];
        end
      end else if (p1_v && !hold_v) begin
        hold_v <= 1'b1;
        hold_d <= base_d;
      end
    end
  end
endmodule

module pix_cmd_alu_chk #(
  parameter int AW = 10
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cmd_valid,
  input logic          cmd_ready,
  input logic          rd_en,
  input logic          wr_valid,
  input logic          wr_ready,
  input logic [AW-1:0] wr_addr,
  input logic [31:0]   wr_data
);
  assert_write_held_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !wr_ready) |=> (wr_valid && $stable(wr_addr) && $stable(wr_data)));
  assert_ready_when_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_valid |-> cmd_ready);
  assert_read_needs_cmd_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |-> cmd_valid);
  assert_no_read_in_stall_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !wr_ready) |-> !rd_en);
endmodule

bind pix_cmd_alu pix_cmd_alu_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .rd_en(rd_en),
  .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_data(wr_data)
);

// File: tb/sim_pix_cmd_alu.sv
module sim_pix_cmd_alu;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 10;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cmd_valid = 1'b0;
  logic          cmd_ready;
  logic [3:0]    cmd_op = '0;
  logic [7:0]    cmd_alpha = '0;
  logic [AW-1:0] cmd_addr = '0;
  logic [31:0]   cmd_data = '0;
  logic          rd_en;
  logic [AW-1:0] rd_addr;
  logic [31:0]   rd_data = '0;
  logic          wr_valid;
  logic          wr_ready = 1'b1;
  logic [AW-1:0] wr_addr;
  logic [31:0]   wr_data;

  int total = 0, bad = 0;
  bit bp_on = 1'b0;
  logic [31:0] mem  [1 << AW];
  logic [31:0] refm [1 << AW];
  logic [AW-1:0] qa[$];
  logic [31:0]   qd[$];
  string         qt[$];
  logic          prev_stall = 1'b0;
  logic [AW-1:0] prev_a = '0;
  logic [31:0]   prev_d = '0;

  pix_cmd_alu #(.AW(AW)) u0 (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    if (rd_en) rd_data <= mem[rd_addr];
    if (wr_valid && wr_ready) mem[wr_addr] <= wr_data;
  end

  always @(posedge clk) begin
    #2;
    wr_ready = bp_on ? ($urandom_range(0, 2) != 0) : 1'b1;
  end

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  always @(negedge clk) if (rst_n) begin
    if (cmd_valid && cmd_ready)
      check(rd_en && rd_addr == cmd_addr, "R2 read issue", 32'(rd_addr), 32'(cmd_addr));
    if (prev_stall)
      check(wr_valid && wr_addr == prev_a && wr_data == prev_d, "R9 write held", wr_data, prev_d);
    if (wr_valid && !wr_ready)
      check(!cmd_ready, "R9 ready low in stall", 32'(cmd_ready), 32'd0);
    else
      check(cmd_ready, "R9 ready high", 32'(cmd_ready), 32'd1);
    prev_stall = wr_valid && !wr_ready;
    prev_a = wr_addr;
    prev_d = wr_data;
    if (wr_valid && wr_ready) begin
      if (qa.size() == 0) check(1'b0, "R7/R10 unexpected write", wr_data, 32'd0);
      else begin
        logic [AW-1:0] ea;
        logic [31:0] ed;
        string et;
        ea = qa.pop_front(); ed = qd.pop_front(); et = qt.pop_front();
        check(wr_addr == ea, {et, " R10 addr"}, 32'(wr_addr), 32'(ea));
        check(wr_data == ed, {et, " R8 data"}, wr_data, ed);
      end
    end
  end

  function automatic void ref_op(input logic [3:0] op, input logic [7:0] a, input logic [31:0] c,
                                 input logic [31:0] s, output logic w, output logic [31:0] r);
    w = 1'b1;
    r = c;
    case (op)
      4'd0: w = 1'b1;
      4'd1: w = c < s;
      4'd2: w = c <= s;
      4'd3: w = c > s;
      4'd4: w = c == s;
      4'd5: w = 1'b0;
      4'd6: for (int b = 0; b < 4; b++) begin
              int cv, sv;
              cv = int'(c[8*b +: 8]);
              sv = int'(s[8*b +: 8]);
              r[8*b +: 8] = 8'((cv * int'(a) + sv * (255 - int'(a)) + 127) / 255);
            end
      4'd8:  r = c & s;
      4'd9:  r = c | s;
      4'd10: r = c ^ s;
      4'd11: r = s & ~c;
      default: w = 1'b0;
    endcase
  endfunction

  task automatic send(input logic [3:0] op, input logic [7:0] a, input logic [AW-1:0] ad,
                      input logic [31:0] d, input string tag);
    logic w;
    logic [31:0] r;
    ref_op(op, a, d, refm[ad], w, r);
    if (w) begin
      refm[ad] = r;
      qa.push_back(ad); qd.push_back(r); qt.push_back(tag);
    end
    @(posedge clk); #1;
    cmd_valid = 1'b1; cmd_op = op; cmd_alpha = a; cmd_addr = ad; cmd_data = d;
    forever begin
      @(negedge clk);
      if (cmd_ready) break;
    end
  endtask

  task automatic idle(input int n);
    @(posedge clk); #1;
    cmd_valid = 1'b0;
    repeat (n) @(posedge clk);
  endtask

  task automatic drain();
    int n = 0;
    idle(0);
    while (qa.size() != 0 && n < 500) begin @(negedge clk); n++; end
    repeat (10) @(negedge clk);
    check(qa.size() == 0, "R8 all writes seen", 32'(qa.size()), 32'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=hung expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int n;
    for (int i = 0; i < (1 << AW); i++) begin
      mem[i]  = (32'(i) * 32'h01010101) ^ 32'h80402010;
      refm[i] = mem[i];
    end
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    check(cmd_ready && !wr_valid && !rd_en, "R1 reset state",
          {29'd0, cmd_ready, wr_valid, rd_en}, 32'd4);

    send(4'd0, 8'd0, 10'd100, 32'hCAFE0001, "R3");
    idle(0);
    n = 1;
    @(negedge clk);
    while (!wr_valid && n < 20) begin @(negedge clk); n++; end
    check(n == 7, "R3 latency", 32'(n), 32'd7);
    drain();

    send(4'd0, 8'd0, 10'd20, 32'h500, "R4 seed");
    send(4'd1, 8'd0, 10'd20, 32'h400, "R4 lt pass");
    send(4'd1, 8'd0, 10'd20, 32'h600, "R4 lt fail");
    send(4'd2, 8'd0, 10'd20, 32'h400, "R4 le equal");
    send(4'd3, 8'd0, 10'd20, 32'h300, "R4 gt fail");
    send(4'd3, 8'd0, 10'd20, 32'h900, "R4 gt pass");
    send(4'd4, 8'd0, 10'd20, 32'h900, "R4 eq pass");
    send(4'd4, 8'd0, 10'd20, 32'h1, "R4 eq fail");
    send(4'd5, 8'd0, 10'd20, 32'h0, "R4 never");
    send(4'd10, 8'd0, 10'd20, 32'h0, "R4 readback");
    drain();

    send(4'd0, 8'd0, 10'd21, 32'h700, "R4 seed spaced");
    idle(10);
    send(4'd1, 8'd0, 10'd21, 32'h800, "R4 lt fail spaced");
    idle(10);
    send(4'd3, 8'd0, 10'd21, 32'h701, "R4 gt pass spaced");
    idle(10);
    send(4'd9, 8'd0, 10'd21, 32'h0, "R4 readback spaced");
    drain();

    send(4'd0, 8'd0, 10'd30, 32'h00FF8040, "R5 seed");
    send(4'd6, 8'd0, 10'd30, 32'hFFFFFFFF, "R5 alpha0");
    send(4'd6, 8'd255, 10'd30, 32'h11223344, "R5 alpha255");
    send(4'd6, 8'd128, 10'd30, 32'hFF00FF00, "R5 alpha128");
    idle(4);
    send(4'd6, 8'd64, 10'd30, 32'h80808080, "R5 alpha64 spaced");
    drain();

    send(4'd0, 8'd0, 10'd40, 32'hF0F0_3C3C, "R6 seed");
    send(4'd8, 8'd0, 10'd40, 32'hFF00_FF00, "R6 and");
    send(4'd9, 8'd0, 10'd40, 32'h0000_00FF, "R6 or");
    send(4'd10, 8'd0, 10'd40, 32'hFFFF_0000, "R6 xor");
    send(4'd11, 8'd0, 10'd40, 32'h0F00_0F0F, "R6 andnot");
    drain();

    send(4'd7, 8'd0, 10'd50, 32'h1111, "R7 op7");
    send(4'd12, 8'd0, 10'd50, 32'h2222, "R7 op12");
    send(4'd15, 8'd0, 10'd50, 32'h3333, "R7 op15");
    send(4'd9, 8'd0, 10'd50, 32'h0, "R7 readback");
    drain();

    bp_on = 1'b1;
    for (int i = 0; i < 400; i++)
      send(4'($urandom_range(0, 15)), 8'($urandom), 10'($urandom_range(0, 5)), $urandom, "R8 random bp");
    drain();
    bp_on = 1'b0;
    repeat (4) @(posedge clk);
    for (int i = 0; i < 200; i++)
      send(4'($urandom_range(0, 11)), 8'($urandom), 10'($urandom_range(0, 2)), $urandom, "R8 random");
    drain();

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule